// File: doc/BRIEF.md
# Console Terminal Interface Controller

This block connects a byte-wide processor I/O bus to a keyboard and printer pair. The processor issues four kinds of operation: a command write, a data read, a data write and a status sense. The block answers with a receive byte, a status byte and a level interrupt request. On the device side, the keyboard delivers single-cycle character strobes, some of which are marked as a break. The printer takes characters through a valid/done handshake.

One busy flag serves both directions. Its meaning depends on the commanded direction. In read mode it shows that no fresh keyboard character is waiting. In write mode it shows that the printer is still printing. When a command flips the direction, busy and the interrupt are evaluated again. A character-pending flag drives overrun detection. In half-duplex mode each received character is echoed to the printer side, masked to 7 bits. The interrupt is gated only by an internal arm flag.

Top module: `con_term_ctrl`

## Requirements
- R1: After a synchronous reset the block is in read mode, full duplex and disarmed. The character-pending flag is clear, `sense_data` reads 0x08 (busy only), `irq` is low, `tx_valid` is low and `echo_valid` is low.
- R2: A command byte holds three 2-bit fields: arm at bits [1:0], read direction at [3:2] and full duplex at [5:4]. A field value of 01 sets its mode bit, 10 clears it, and 00 or 11 keeps it. The other command bits are ignored.
- R3: Suppose a command changes the direction. Busy clears, and `irq` rises if the new arm is set, when the change is to read with a character pending or to write with the transmitter idle. In every other direction change, busy sets and `irq` drops.
- R4: A command that keeps the direction clears the overrun bit and changes neither busy, break nor `irq`.
- R5: A data read returns the receive buffer on `rd_data` and clears character-pending. In read mode it also sets busy and clears overrun.
- R6: A data write latches `wr_data`. `tx_valid` then goes high with that byte on `tx_char`, and stays high until `tx_done`. In write mode the write also sets busy.
- R7: `tx_done` while `tx_valid` is high ends the transfer. In write mode it also clears busy and raises `irq` if armed. `tx_done` while idle is ignored.
- R8: A received character first clears break. In read mode it then clears busy, raises `irq` if armed, and sets overrun if a character was already pending. Character-pending is set in every mode.
- R9: A received break sets the break bit and loads 0x00 into the receive buffer. It is otherwise handled like a character.
- R10: `sense_data` carries overrun at bit 7, break at bit 5, busy at bit 3, and at bit 2 an examine bit that is the OR of overrun and break. All other bits are zero.
- R11: In half duplex, a received non-break character appears on `echo_char`, masked to 7 bits, with `echo_valid` high for one cycle on the next cycle.
- R12: `irq` is a level. Once raised, it stays high until a direction-changing command withdraws it or a reset occurs.
- R13: Within one cycle the block applies transmit completion first, then one bus operation, then a received character. Bus operations take precedence in the order command, read, write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Receive buffer |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| sense_data | output | 8 | Status byte |
| irq | output | 1 | Interrupt request level |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | Strobe carries a break |
| tx_valid | output | 1 | Transmit character valid |
| tx_char | output | 8 | Transmit character |
| tx_done | input | 1 | Printer accepted the character |
| echo_valid | output | 1 | Echo character valid |
| echo_char | output | 8 | Echoed character, bit 7 zero |

## Verification
Every output comes straight from a register, so a wrong internal state shows up at the ports on the cycle after the operation that caused it. A stale character-pending flag does not show itself directly. It appears as a missing or spurious overrun on the next receive, or as the wrong busy value after a switch to read. A wrong transmitter-idle view shows up the same way, through busy and `irq` after a switch to write. The bench therefore mixes direction changes with receive and transmit events, including same-cycle collisions, so that these hidden flags become visible within one or two operations.

// File: rtl/con_term_pkg.sv
package con_term_pkg;

    parameter int BYTE_W = 8;
    parameter int ECHO_W = 7;

    // status bit positions
    localparam int ST_OVR  = 7;
    localparam int ST_BRK  = 5;
    localparam int ST_BUSY = 3;
    localparam int ST_EX   = 2;

    // command field low bit positions
    localparam int CF_ARM = 0;
    localparam int CF_RD  = 2;
    localparam int CF_FDX = 4;

    typedef enum logic [1:0] {
        PAIR_HOLD_A = 2'b00,
        PAIR_SET    = 2'b01,
        PAIR_CLR    = 2'b10,
        PAIR_HOLD_B = 2'b11
    } pair_e;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic rd_mode;
        logic fdx;
        logic arm;
    } mode_t;

    function automatic logic apply_pair(input logic [1:0] fld, input logic cur);
        logic r;
        case (pair_e'(fld))
            PAIR_SET: r = 1'b1;
            PAIR_CLR: r = 1'b0;
            default:  r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input stat_t s);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[ST_OVR]  = s.ovr;
        b[ST_BRK]  = s.brk;
        b[ST_BUSY] = s.busy;
        b[ST_EX]   = s.ovr | s.brk;
        return b;
    endfunction

endpackage

// File: rtl/con_term_cmd_dec.sv
module con_term_cmd_dec
    import con_term_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    input  mode_t             cur,
    output mode_t             nxt,
    output logic              dir_chg
);
    always_comb begin
        nxt.arm     = apply_pair(cmd[CF_ARM+1:CF_ARM], cur.arm);
        nxt.rd_mode = apply_pair(cmd[CF_RD+1:CF_RD],   cur.rd_mode);
        nxt.fdx     = apply_pair(cmd[CF_FDX+1:CF_FDX], cur.fdx);
        dir_chg     = nxt.rd_mode != cur.rd_mode;
    end
endmodule

// File: rtl/con_term_tx.sv
module con_term_tx
    import con_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    input  logic              done,
    output logic              active,
    output logic              idle_now,
    output logic              cpl,
    output logic [BYTE_W-1:0] char_q
);
    assign cpl      = active & done;
    assign idle_now = ~active | done;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            char_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            char_q <= din;
        end else if (cpl) begin
            active <= 1'b0;
        end
    end

    // R7: a completed transfer with no new write leaves the channel idle
    a_r7_done_ends: assert property (@(posedge clk) disable iff (rst)
        (active && done && !start) |=> !active);
    // R6: a write keeps the byte on the channel
    a_r6_start_holds: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && char_q == $past(din)));
endmodule

// File: rtl/con_term_echo.sv
module con_term_echo
    import con_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              is_brk,
    input  logic              half,
    input  logic [BYTE_W-1:0] din,
    output logic              echo_v,
    output logic [BYTE_W-1:0] echo_c
);
    localparam logic [BYTE_W-1:0] ECHO_MASK = BYTE_W'((1 << ECHO_W) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_v <= 1'b0;
            echo_c <= '0;
        end else begin
            echo_v <= fire & half & ~is_brk;
            if (fire & half & ~is_brk)
                echo_c <= din & ECHO_MASK;
        end
    end

    // R11: an echo only follows a non-break receive
    a_r11_echo_cause: assert property (@(posedge clk) disable iff (rst)
        echo_v |-> ($past(fire) && !$past(is_brk)));
    // R11: echoed bytes never carry bit 7
    a_r11_echo_masked: assert property (@(posedge clk) disable iff (rst)
        echo_v |-> !echo_c[BYTE_W-1]);
endmodule

// File: rtl/con_term_ctrl.sv
module con_term_ctrl
    import con_term_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  sense_data,
    output logic        irq,
    input  logic        rx_valid,
    input  logic [7:0]  rx_char,
    input  logic        rx_break,
    output logic        tx_valid,
    output logic [7:0]  tx_char,
    input  logic        tx_done,
    output logic        echo_valid,
    output logic [7:0]  echo_char
);
    mode_t             mode_q, mode_d, dec_mode;
    stat_t             st_q, st_d;
    logic              chp_q, chp_d;
    logic              irq_q, irq_d;
    logic [BYTE_W-1:0] rbuf_q, rbuf_d;
    logic              dir_chg;
    logic              tx_start, tx_idle, tx_cpl, tx_act;
    logic              do_rd, do_wr;

    assign do_rd    = rd_en & ~cmd_wr;
    assign do_wr    = wr_en & ~cmd_wr & ~rd_en;
    assign tx_start = do_wr;

    con_term_cmd_dec u_dec (
        .cmd     (cmd_data),
        .cur     (mode_q),
        .nxt     (dec_mode),
        .dir_chg (dir_chg)
    );

    con_term_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (tx_start),
        .din      (wr_data),
        .done     (tx_done),
        .active   (tx_act),
        .idle_now (tx_idle),
        .cpl      (tx_cpl),
        .char_q   (tx_char)
    );

    con_term_echo u_echo (
        .clk    (clk),
        .rst    (rst),
        .fire   (rx_valid),
        .is_brk (rx_break),
        .half   (~mode_d.fdx),
        .din    (rx_char),
        .echo_v (echo_valid),
        .echo_c (echo_char)
    );

    // ordered update: transmit completion, bus operation, receive
    always_comb begin
        mode_d = mode_q;
        st_d   = st_q;
        chp_d  = chp_q;
        irq_d  = irq_q;
        rbuf_d = rbuf_q;

        if (tx_cpl && !mode_q.rd_mode) begin
            st_d.busy = 1'b0;
            if (mode_q.arm) irq_d = 1'b1;
        end

        if (cmd_wr) begin
            mode_d = dec_mode;
            if (dir_chg) begin
                if (dec_mode.rd_mode ? chp_q : tx_idle) begin
                    st_d.busy = 1'b0;
                    if (dec_mode.arm) irq_d = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    irq_d     = 1'b0;
                end
            end else begin
                st_d.ovr = 1'b0;
            end
        end else if (do_rd) begin
            chp_d = 1'b0;
            if (mode_q.rd_mode) begin
                st_d.busy = 1'b1;
                st_d.ovr  = 1'b0;
            end
        end else if (do_wr) begin
            if (!mode_q.rd_mode) st_d.busy = 1'b1;
        end

        if (rx_valid) begin
            st_d.brk = 1'b0;
            if (mode_d.rd_mode) begin
                st_d.busy = 1'b0;
                if (mode_d.arm) irq_d = 1'b1;
                if (chp_d) st_d.ovr = 1'b1;
            end
            chp_d = 1'b1;
            if (rx_break) begin
                st_d.brk = 1'b1;
                rbuf_d   = '0;
            end else begin
                rbuf_d = rx_char;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{rd_mode: 1'b1, fdx: 1'b1, arm: 1'b0};
            st_q   <= '{ovr: 1'b0, brk: 1'b0, busy: 1'b1};
            chp_q  <= 1'b0;
            irq_q  <= 1'b0;
            rbuf_q <= '0;
        end else begin
            mode_q <= mode_d;
            st_q   <= st_d;
            chp_q  <= chp_d;
            irq_q  <= irq_d;
            rbuf_q <= rbuf_d;
        end
    end

    assign rd_data    = rbuf_q;
    assign sense_data = pack_status(st_q);
    assign irq        = irq_q;
    assign tx_valid   = tx_act;

    // R1: state right after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sense_data == 8'h08 && !irq && !tx_valid && !chp_q));
    // R12: the request only falls through a command
    a_r12_irq_level: assert property (@(posedge clk) disable iff (rst)
        (irq && !cmd_wr) |=> irq);
    // R5: a read with no receive leaves nothing pending
    a_r5_read_clears_pend: assert property (@(posedge clk) disable iff (rst)
        (do_rd && !rx_valid) |=> !chp_q);
    // R9: a break loads zero and flags break
    a_r9_break_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_break) |=> (rd_data == '0 && sense_data[ST_BRK]));
    // R8: every receive leaves a character pending
    a_r8_pending_set: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> chp_q);
    // R6: a write in write mode leaves busy set
    a_r6_write_busy: assert property (@(posedge clk) disable iff (rst)
        (do_wr && !mode_q.rd_mode) |=> sense_data[ST_BUSY]);
    // R4: a command that keeps direction drops overrun unless a receive lands
    a_r4_ovr_cleared: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !dir_chg && !rx_valid) |=> !sense_data[ST_OVR]);
endmodule

// File: tb/con_term_ctrl_bench.sv
module con_term_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_wr = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic       rx_valid = 1'b0, rx_break = 1'b0, tx_done = 1'b0;
    logic [7:0] cmd_data = '0, wr_data = '0, rx_char = '0;
    logic [7:0] rd_data, sense_data, tx_char, echo_char;
    logic       irq, tx_valid, echo_valid;

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    string cur_tag = "R1";
    string chk_tag = "R1";
    bit    started = 1'b0;

    // reference state
    int m_rd, m_fdx, m_arm, m_ovr, m_brk, m_busy, m_chp, m_irq, m_rbuf;
    int m_txa, m_txc, m_ev, m_ec;

    always #5 clk = ~clk;

    con_term_ctrl u_con_term_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
        .sense_data(sense_data), .irq(irq), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_break(rx_break), .tx_valid(tx_valid),
        .tx_char(tx_char), .tx_done(tx_done), .echo_valid(echo_valid),
        .echo_char(echo_char)
    );

    function automatic int pair(input int fld, input int cur);
        if (fld == 1) return 1;
        if (fld == 2) return 0;
        return cur;
    endfunction

    always @(posedge clk) begin
        int new_rd, old_rd;
        chk_tag <= cur_tag;
        started <= 1'b1;
        cycles  <= cycles + 1;
        if (rst) begin
            m_rd = 1; m_fdx = 1; m_arm = 0; m_ovr = 0; m_brk = 0; m_busy = 1;
            m_chp = 0; m_irq = 0; m_rbuf = 0; m_txa = 0; m_txc = 0;
            m_ev = 0; m_ec = 0;
        end else begin
            bit idle_now;
            idle_now = (m_txa == 0) || tx_done;
            if (m_txa == 1 && tx_done) begin
                m_txa = 0;
                if (m_rd == 0) begin m_busy = 0; if (m_arm == 1) m_irq = 1; end
            end
            if (cmd_wr) begin
                old_rd = m_rd;
                m_arm  = pair(int'(cmd_data[1:0]), m_arm);
                new_rd = pair(int'(cmd_data[3:2]), m_rd);
                m_fdx  = pair(int'(cmd_data[5:4]), m_fdx);
                m_rd   = new_rd;
                if (new_rd != old_rd) begin
                    if ((new_rd == 1) ? (m_chp == 1) : idle_now) begin
                        m_busy = 0; if (m_arm == 1) m_irq = 1;
                    end else begin
                        m_busy = 1; m_irq = 0;
                    end
                end else m_ovr = 0;
            end else if (rd_en) begin
                m_chp = 0;
                if (m_rd == 1) begin m_busy = 1; m_ovr = 0; end
            end else if (wr_en) begin
                m_txa = 1; m_txc = wr_data;
                if (m_rd == 0) m_busy = 1;
            end
            m_ev = 0;
            if (rx_valid) begin
                m_brk = 0;
                if (m_rd == 1) begin
                    m_busy = 0;
                    if (m_arm == 1) m_irq = 1;
                    if (m_chp == 1) m_ovr = 1;
                end
                m_chp = 1;
                if (rx_break) begin m_brk = 1; m_rbuf = 0; end
                else m_rbuf = rx_char;
                if (m_fdx == 0 && !rx_break) begin m_ev = 1; m_ec = rx_char % 128; end
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", chk_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("sense_data (R10)", int'(sense_data),
                m_ovr * 128 + m_brk * 32 + m_busy * 8 + ((m_ovr | m_brk) != 0 ? 4 : 0));
            chk("irq", int'(irq), m_irq);
            chk("rd_data", int'(rd_data), m_rbuf);
            chk("tx_valid", int'(tx_valid), m_txa);
            if (m_txa == 1) chk("tx_char", int'(tx_char), m_txc);
            chk("echo_valid", int'(echo_valid), m_ev);
            if (m_ev == 1) chk("echo_char", int'(echo_char), m_ec);
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(input string tag, input bit cw, input int cd, input bit re,
                        input bit we, input int wd, input bit rv, input int rc,
                        input bit rb, input bit td);
        @(negedge clk);
        cur_tag  = tag;
        cmd_wr   = cw; cmd_data = 8'(cd);
        rd_en    = re;
        wr_en    = we; wr_data  = 8'(wd);
        rx_valid = rv; rx_char  = 8'(rc); rx_break = rb;
        tx_done  = td;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic cmd(input string tag, input int v);
        step(tag, 1, v, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rx(input string tag, input int c, input bit b);
        step(tag, 0, 0, 0, 0, 0, 1, c, b, 0);
    endtask
    task automatic rdop(input string tag);
        step(tag, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wrop(input string tag, input int v);
        step(tag, 0, 0, 0, 1, v, 0, 0, 0, 0);
    endtask
    task automatic done(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle("R1", 2);
        rst = 1'b0;
        idle("R1", 2);
        rx("R8", 8'h41, 0);     idle("R8", 1);
        rx("R8", 8'h42, 0);     idle("R10", 2);
        cmd("R4", 8'h00);       idle("R4", 1);
        rdop("R5");             idle("R5", 1);
        cmd("R2", 8'h01);       cmd("R2", 8'h03);  cmd("R2", 8'hC0);
        rx("R9", 8'h7F, 1);     idle("R9", 1);
        rx("R8", 8'h33, 0);     idle("R12", 2);
        rdop("R12");            idle("R12", 2);
        cmd("R3", 8'h08);       idle("R3", 1);
        wrop("R6", 8'h5A);      idle("R6", 3);
        cmd("R3", 8'h04);       idle("R3", 1);
        cmd("R3", 8'h08);       idle("R3", 1);
        done("R7");             idle("R7", 1);
        done("R7");             idle("R7", 1);
        cmd("R3", 8'h04);       rx("R8", 8'h20, 0); cmd("R3", 8'h08);
        wrop("R6", 8'hA5);      rdop("R5"); cmd("R3", 8'h04); idle("R3", 1);
        cmd("R11", 8'h20);      rx("R11", 8'hC1, 0); idle("R11", 1);
        rx("R11", 8'h55, 1);    idle("R11", 1);
        rx("R11", 8'hFF, 0);    idle("R11", 1);
        cmd("R2", 8'h10);       rx("R2", 8'h44, 0); idle("R2", 1);
        step("R13", 0, 0, 1, 0, 0, 1, 8'h61, 0, 0); idle("R13", 1);
        step("R13", 0, 0, 1, 0, 0, 1, 8'h62, 0, 0); idle("R13", 1);
        cmd("R13", 8'h08);
        wrop("R13", 8'h11);
        step("R13", 0, 0, 0, 1, 8'h22, 0, 0, 0, 1); idle("R13", 1);
        step("R13", 1, 8'h04, 0, 0, 0, 1, 8'h63, 0, 1); idle("R13", 1);
        step("R13", 1, 8'h08, 1, 1, 8'h77, 0, 0, 0, 0); idle("R13", 1);
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            step("R13", k == 0, int'($urandom_range(0, 255)), k == 1 || k == 7,
                 k == 2 || k == 7, int'($urandom_range(0, 255)),
                 k >= 3 && k <= 5, int'($urandom_range(0, 255)),
                 $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0);
        end
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        idle("R1", 2);
        rst = 1'b0;
        idle("R1", 3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule